// File: doc/BRIEF.md
# Quiz Buzzer Arbiter with Countdown

This block runs one answer round of a game-show contest. A host control line selects between a clear state and a running state. Eight contestant buttons arrive as active-low inputs. A single-cycle tick enable marks each elapsed second. When the round is armed, the first cycle with any button down picks one winner by fixed priority. The block stores that contestant's number, shows it, raises an alarm enable and stops the countdown timer. The timer is a two-digit BCD down-counter and keeps showing the seconds that were left.

If the count runs out first, the timer stays at 00, no further press is taken, and the alarm enable stays high until the host clears the round. A new round always needs a clear followed by a fresh start. Seven-segment decoding, tone generation, button debouncing and tick generation happen outside this block.

Top module: `quiz_arbiter`

## Requirements
- R1: When several buttons are low in the same cycle, the highest-indexed one wins. `winner_o` then reads index+1, giving 1 for `buzz_ni[0]` through 8 for `buzz_ni[7]`.
- R2: Out of reset, and from the cycle after any clock edge that samples `start_i` low, the outputs are held in the clear state: `winner_o`=0, `blank_o`=1, `alarm_o`=0, and the timer shows the preset (default tens=3, ones=0). Button presses have no effect in this state.
- R3: A round is armed only by a clock edge that samples `start_i` high after an edge that sampled it low. If `start_i` is already high when reset is released, nothing is armed.
- R4: Once a winner is latched, `winner_o` does not change, whatever the buttons do, until the next clear.
- R5: While armed, each tick lowers the timer by one second in BCD: 30, 29, …, 10, 09, …, 00. Each digit stays in the range 0 to 9.
- R6: After a press is accepted, the timer keeps the value it had when the press arrived, and ticks do not change it.
- R7: An accepted press sets `alarm_o` and clears `blank_o`. `alarm_o` stays high for ALARM_TICKS ticks (default 1) and then drops. The number and the timer stay shown after that.
- R8: Once the timer reaches 00 with no winner, it holds at 00 and presses are refused. From the following clock edge, `alarm_o` stays high until a clear.
- R9: When a press and a tick arrive in the same cycle, the press is accepted and the timer is not decremented.
- R10: A press sampled at a clock edge shows up on `winner_o`, `blank_o` and `alarm_o` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Host control: 0 = clear, 1 = start |
| tick_i | input | 1 | One-cycle pulse, once per second |
| buzz_ni | input | 8 | Contestant buttons, active low |
| winner_o | output | 4 | Latched contestant number 1..8, 0 when none |
| blank_o | output | 1 | High when the number display is blank |
| tens_o | output | 4 | Timer tens digit, BCD |
| ones_o | output | 4 | Timer ones digit, BCD |
| alarm_o | output | 1 | Sounder enable |

## Verification
The bench sweeps all 255 non-empty button patterns, each in a fresh round. This catches an encoder that favours the low index, or one whose number is off by one. After each win it presses every button at once; a latch that is still open would change its number. A full countdown covers the 10-to-09 borrow, the hold at 00, and a press refused at 00; a wrong borrow would show an invalid digit or skip a value. Further cases cover a press and a tick in the same cycle, a start held high out of reset that must not arm, and the alarm drop after its tick window. An alarm that never drops, or a timer that moves after a win, would be caught there.

// File: rtl/quiz_pkg.sv
`timescale 1ns/1ps
package quiz_pkg;
  typedef enum logic [1:0] {
    ST_CLEAR   = 2'd0,
    ST_RUN     = 2'd1,
    ST_WON     = 2'd2,
    ST_TIMEOUT = 2'd3
  } quiz_state_e;

  typedef logic [3:0] bcd_t;
endpackage

// File: rtl/quiz_prio_enc.sv
`timescale 1ns/1ps
module quiz_prio_enc #(
  parameter int N = 8,
  parameter int W = 4
) (
  input  logic [N-1:0] req_i,
  output logic         hit_o,
  output logic [W-1:0] num_o
);
  // later (higher) index overrides earlier
  always_comb begin
    hit_o = |req_i;
    num_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) num_o = W'(i + 1);
    end
  end
endmodule

// File: rtl/quiz_bcd_timer.sv
`timescale 1ns/1ps
module quiz_bcd_timer
  import quiz_pkg::*;
#(
  parameter bcd_t INIT_TENS = 4'd3,
  parameter bcd_t INIT_ONES = 4'd0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output bcd_t tens_o,
  output bcd_t ones_o,
  output logic zero_o
);
  bcd_t tens_q, ones_q;

  assign zero_o = (tens_q == 4'd0) && (ones_q == 4'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tens_q <= INIT_TENS;
      ones_q <= INIT_ONES;
    end else if (load_i) begin
      tens_q <= INIT_TENS;
      ones_q <= INIT_ONES;
    end else if (dec_i && !zero_o) begin
      if (ones_q == 4'd0) begin
        ones_q <= 4'd9;
        tens_q <= tens_q - 4'd1;
      end else begin
        ones_q <= ones_q - 4'd1;
      end
    end
  end

  assign tens_o = tens_q;
  assign ones_o = ones_q;

  AST_DIGIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tens_q <= 4'd9) && (ones_q <= 4'd9)); // R5
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && !zero_o) |=>
      ({4'd0, $past(tens_q)} * 8'd10 + {4'd0, $past(ones_q)})
        == ({4'd0, tens_q} * 8'd10 + {4'd0, ones_q} + 8'd1)); // R5
endmodule

// File: rtl/quiz_ctrl.sv
`timescale 1ns/1ps
module quiz_ctrl
  import quiz_pkg::*;
#(
  parameter int W           = 4,
  parameter int ALARM_TICKS = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         tick_i,
  input  logic         hit_i,
  input  logic [W-1:0] num_i,
  input  logic         zero_i,
  output logic         load_o,
  output logic         dec_o,
  output logic [W-1:0] winner_o,
  output logic         blank_o,
  output logic         alarm_o
);
  localparam int CW = $clog2(ALARM_TICKS + 1);

  quiz_state_e    st_q;
  logic           start_q;
  logic [W-1:0]   winner_q;
  logic           alarm_q;
  logic [CW-1:0]  acnt_q;
  logic           arm;

  assign arm = start_i && !start_q;

  // start_q resets high so a start held through reset does not arm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b1;
    else         start_q <= start_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_CLEAR;
      winner_q <= '0;
      alarm_q  <= 1'b0;
      acnt_q   <= '0;
    end else if (!start_i) begin
      st_q     <= ST_CLEAR;
      winner_q <= '0;
      alarm_q  <= 1'b0;
      acnt_q   <= '0;
    end else begin
      unique case (st_q)
        ST_CLEAR: if (arm) st_q <= ST_RUN;
        ST_RUN: begin
          if (zero_i) begin
            st_q    <= ST_TIMEOUT;
            alarm_q <= 1'b1;
          end else if (hit_i) begin
            st_q     <= ST_WON;
            winner_q <= num_i;
            alarm_q  <= 1'b1;
            acnt_q   <= CW'(ALARM_TICKS);
          end
        end
        ST_WON: begin
          if (tick_i && alarm_q) begin
            if (acnt_q <= CW'(1)) begin
              alarm_q <= 1'b0;
              acnt_q  <= '0;
            end else begin
              acnt_q <= acnt_q - CW'(1);
            end
          end
        end
        ST_TIMEOUT: ;
        default: st_q <= ST_CLEAR;
      endcase
    end
  end

  assign load_o   = !start_i || (st_q == ST_CLEAR);
  assign dec_o    = start_i && (st_q == ST_RUN) && tick_i && !hit_i && !zero_i;
  assign winner_o = winner_q;
  assign blank_o  = (st_q != ST_WON);
  assign alarm_o  = alarm_q;

  AST_CLEAR_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (blank_o && winner_o == '0 && !alarm_o)); // R2
  AST_NO_ARM_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CLEAR && start_q) |=> (st_q == ST_CLEAR)); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WON && start_i) |=> $stable(winner_o)); // R4
  AST_WIN_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && start_i && hit_i && !zero_i) |=> (alarm_o && !blank_o)); // R7
  AST_TIMEOUT_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TIMEOUT && start_i) |=> (alarm_o && blank_o)); // R8
endmodule

// File: rtl/quiz_arbiter.sv
`timescale 1ns/1ps
module quiz_arbiter
  import quiz_pkg::*;
#(
  parameter int   N_PLAYERS   = 8,
  parameter bcd_t PRESET_TENS = 4'd3,
  parameter bcd_t PRESET_ONES = 4'd0,
  parameter int   ALARM_TICKS = 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic                           tick_i,
  input  logic [N_PLAYERS-1:0]           buzz_ni,
  output logic [$clog2(N_PLAYERS+1)-1:0] winner_o,
  output logic                           blank_o,
  output logic [3:0]                     tens_o,
  output logic [3:0]                     ones_o,
  output logic                           alarm_o
);
  localparam int NW = $clog2(N_PLAYERS + 1);

  logic          hit, load, dec, zero;
  logic [NW-1:0] num;

  quiz_prio_enc #(.N(N_PLAYERS), .W(NW)) u_enc (
    .req_i (~buzz_ni),
    .hit_o (hit),
    .num_o (num)
  );

  quiz_bcd_timer #(.INIT_TENS(PRESET_TENS), .INIT_ONES(PRESET_ONES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .dec_i  (dec),
    .tens_o (tens_o),
    .ones_o (ones_o),
    .zero_o (zero)
  );

  quiz_ctrl #(.W(NW), .ALARM_TICKS(ALARM_TICKS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .tick_i   (tick_i),
    .hit_i    (hit),
    .num_i    (num),
    .zero_i   (zero),
    .load_o   (load),
    .dec_o    (dec),
    .winner_o (winner_o),
    .blank_o  (blank_o),
    .alarm_o  (alarm_o)
  );

  AST_WON_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_o && start_i) |=> ($stable(tens_o) && $stable(ones_o))); // R6
  AST_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero && start_i && blank_o && alarm_o) |=> (tens_o == 4'd0 && ones_o == 4'd0)); // R8
endmodule

// File: tb/quiz_arbiter_tb.sv
`timescale 1ns/1ps
module quiz_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] buzz_n = 8'hFF;
  logic [3:0] winner, tens, ones;
  logic       blank, alarm;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quiz_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tick_i(tick),
    .buzz_ni(buzz_n), .winner_o(winner), .blank_o(blank),
    .tens_o(tens), .ones_o(ones), .alarm_o(alarm)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic new_round();
    start = 1'b0; step();
    start = 1'b1; step();
  endtask

  task automatic do_tick();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  function automatic int top_num(input logic [7:0] p);
    for (int i = 7; i >= 0; i--) if (p[i]) return i + 1;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    #1;
    step(); step();
    rst_n = 1'b1;
    // R2 reset state
    chk("R2 winner", winner, 0);
    chk("R2 blank", blank, 1);
    chk("R2 alarm", alarm, 0);
    chk("R2 tens", tens, 3);
    chk("R2 ones", ones, 0);
    // R3 start held high through reset does not arm
    step(); buzz_n = 8'h7F; step();
    chk("R3 no arm blank", blank, 1);
    chk("R3 no arm winner", winner, 0);
    buzz_n = 8'hFF;
    // R2 presses ignored in clear
    start = 1'b0; step();
    buzz_n = 8'h00; step(); step();
    chk("R2 clear blank", blank, 1);
    chk("R2 clear alarm", alarm, 0);
    buzz_n = 8'hFF;

    // R1 R4 R10 sweep of every pattern
    for (int p = 1; p < 256; p++) begin
      new_round();
      buzz_n = ~8'(p); step();
      chk("R1 winner", winner, top_num(8'(p)));
      chk("R10 blank", blank, 0);
      chk("R7 alarm", alarm, 1);
      buzz_n = 8'h00; step();
      chk("R4 lock", winner, top_num(8'(p)));
      buzz_n = 8'hFF;
    end

    // R5 R8 full countdown
    new_round();
    for (int i = 29; i >= 0; i--) begin
      do_tick();
      chk("R5 tens", tens, i / 10);
      chk("R5 ones", ones, i % 10);
    end
    buzz_n = 8'hFE; step();
    chk("R8 alarm", alarm, 1);
    chk("R8 refused", blank, 1);
    buzz_n = 8'hFF;
    for (int k = 0; k < 4; k++) do_tick();
    chk("R8 hold tens", tens, 0);
    chk("R8 hold ones", ones, 0);
    chk("R8 alarm held", alarm, 1);
    chk("R8 winner", winner, 0);

    // R6 R7 freeze and alarm window
    new_round();
    for (int k = 0; k < 5; k++) do_tick();
    v = 25;
    buzz_n = 8'hFA; step();
    chk("R1 pick", winner, 3);
    buzz_n = 8'hFF;
    do_tick();
    chk("R7 alarm drop", alarm, 0);
    chk("R7 winner kept", winner, 3);
    for (int k = 0; k < 3; k++) do_tick();
    chk("R6 tens", tens, v / 10);
    chk("R6 ones", ones, v % 10);
    chk("R7 still low", alarm, 0);

    // R9 press and tick together
    new_round();
    do_tick(); do_tick();
    tick = 1'b1; buzz_n = 8'hEF; step();
    tick = 1'b0; buzz_n = 8'hFF;
    chk("R9 winner", winner, 5);
    chk("R9 tens", tens, 2);
    chk("R9 ones", ones, 8);

    // R2 clear restores preset
    start = 1'b0; step();
    chk("R2 after clear tens", tens, 3);
    chk("R2 after clear blank", blank, 1);
    chk("R2 after clear winner", winner, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule